// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip sink for a trace stream. While capture is on, each valid 32-bit trace word goes into a circular RAM at the write pointer, and the pointer then advances. A small register bus gives software access to the pointers, the status bits and the control bits. Software clears and drains the RAM through two data ports. Each access to a data port stores or fetches the word at the matching pointer and then advances that pointer. No RAM word is addressed directly.

Capture can end in three ways. The first is a programmed number of words after a trigger. The second is the completion of a manual flush. The third is software clearing the enable bit. Trace is organised in 4-word frames. When capture ends under trigger or flush control, the block first fills out the current frame, using incoming words or a pad word. The write pointer therefore always stops on a frame boundary. A status bit shows when the RAM has wrapped, so software can tell whether older trace was overwritten.

Top module: `trace_ring_sink`

## Requirements
- R1: Address 0x004 reads as the RAM depth in 32-bit words (64 with default parameters), with bit 31 clear. Writes to it have no effect.
- R2: A read strobe at 0x010 returns the RAM word at the read pointer, and the read pointer then advances by one. After index depth-1 it continues at index 0. The read pointer is at 0x014, readable and writable. Bus read data is valid in the cycle after the read strobe.
- R3: Each write to 0x024 stores the bus data at the write pointer and advances the pointer. A write to 0x018 loads the write pointer at once and leaves the RAM contents unchanged.
- R4: Bit 0 of the control register at 0x020 enables capture. While it is set, each cycle with trace_valid stores trace_data at the write pointer and advances the pointer. While it is clear, the trace stream has no effect on the pointer or the RAM.
- R5: Bit 0 of the status register at 0x00C sets when the write pointer wraps from depth-1 to 0, and then stays set. A write pointer write while capture is enabled leaves both this bit and the RAM unchanged. The bit clears only on a write pointer write while capture is disabled.
- R6: The trigger counter at 0x01C is readable and writable. Once a trigger has been accepted during capture, each trace word captured in a later cycle decrements the counter, and the counter holds at zero.
- R7: Bit 13 of the formatter control register at 0x304 enables stop-on-trigger. With it set, once the trigger has been seen and the counter is zero, capture fills the rest of the current 4-word frame and then halts. Each remaining slot takes the incoming word, or PAD_WORD (default 0) in a cycle without one. After the halt, trace input is ignored.
- R8: Writing 1 to bit 6 of 0x304 requests a manual flush. The bit reads 1 while the flush is pending. The flush pads to the next frame boundary as in R7, and the bit then clears by itself. If capture is not running, the bit clears in the next cycle. Bit 0 of 0x304 is a stored formatting-enable flag.
- R9: With bit 12 of 0x304 set, completion of a flush halts capture. With bit 12 clear, capture continues after the flush.
- R10: Bit 1 of the formatter status register at 0x300 reads 1 when capture has halted or is disabled. Writing the control register with bit 0 set re-arms capture: it clears the halted state and the seen-trigger state.
- R11: After reset, all pointers, flags, the counter and the control bits are zero. The formatter status therefore reads 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid the cycle after bus_rd |
| trc_data | input | 32 | Incoming trace word |
| trc_valid | input | 1 | trc_data holds a word this cycle |
| trc_trigger | input | 1 | Trigger event pulse |

## Verification
The capture path is driven in several ways:
- An uninterrupted stream tests the trigger countdown. Its last captured word shows whether exactly the programmed number of words followed the trigger.
- A stream that stops right after the trigger exercises the pad path. Padding is told apart from captured trace because the RAM was first filled with all-ones.
- A stream that crosses the top of the RAM separates wrap-and-full behaviour from plain advancing.
- Streams sent while capture is disabled or halted show whether the pointer and the RAM stay unchanged.
- Flushes are requested with a partial frame, with and without stop-on-flush, and while capture is off. These tell self-clearing, halting and immediate completion apart.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam int WORD_W     = 32;
    localparam int BUS_AW     = 12;
    localparam int FRAME_LOG2 = 2;

    // register byte addresses
    localparam logic [BUS_AW-1:0] A_DEPTH = 12'h004;
    localparam logic [BUS_AW-1:0] A_STAT  = 12'h00C;
    localparam logic [BUS_AW-1:0] A_RDATA = 12'h010;
    localparam logic [BUS_AW-1:0] A_RPTR  = 12'h014;
    localparam logic [BUS_AW-1:0] A_WPTR  = 12'h018;
    localparam logic [BUS_AW-1:0] A_TCNT  = 12'h01C;
    localparam logic [BUS_AW-1:0] A_CTRL  = 12'h020;
    localparam logic [BUS_AW-1:0] A_WDATA = 12'h024;
    localparam logic [BUS_AW-1:0] A_FSTAT = 12'h300;
    localparam logic [BUS_AW-1:0] A_FCTRL = 12'h304;

    // bit positions
    localparam int CT_EN         = 0;
    localparam int ST_FULL       = 0;
    localparam int FS_HALTED     = 1;
    localparam int FC_FMT_EN     = 0;
    localparam int FC_FLUSH      = 6;
    localparam int FC_STOP_FLUSH = 12;
    localparam int FC_STOP_TRIG  = 13;

    typedef struct packed {
        logic stop_flush;
        logic stop_trig;
    } halt_cfg_t;

    typedef struct packed {
        logic              wptr_wr;
        logic              wdata_wr;
        logic              tcnt_wr;
        logic              flush_req;
        logic              arm;
        logic [WORD_W-1:0] value;
    } sw_cmd_t;

    function automatic logic frame_aligned(input logic [FRAME_LOG2-1:0] low);
        return low == '0;
    endfunction

endpackage

// File: rtl/trs_ram.sv
module trs_ram #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/trs_capture.sv
module trs_capture
    import trs_pkg::*;
#(
    parameter int                AW       = 6,
    parameter int                CNT_W    = 16,
    parameter logic [WORD_W-1:0] PAD_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_en,
    input  halt_cfg_t         cfg,
    input  sw_cmd_t           cmd,
    input  logic [WORD_W-1:0] trc_data,
    input  logic              trc_valid,
    input  logic              trc_trigger,
    output logic [AW-1:0]     wptr,
    output logic              full,
    output logic              halted,
    output logic              flush_busy,
    output logic [CNT_W-1:0]  tcnt,
    output logic              ram_we,
    output logic [AW-1:0]     ram_waddr,
    output logic [WORD_W-1:0] ram_wdata
);
    logic seen_trig;
    logic active, aligned, trig_done, drain, halt_now;
    logic pad_wr, trc_wr, hw_wr, flush_done, sw_hold;

    always_comb begin
        active     = ctl_en && !halted;
        aligned    = frame_aligned(wptr[FRAME_LOG2-1:0]);
        trig_done  = seen_trig && (tcnt == '0) && cfg.stop_trig;
        drain      = active && (trig_done || flush_busy);
        halt_now   = active && aligned && (trig_done || (flush_busy && cfg.stop_flush));
        pad_wr     = drain && !aligned && !trc_valid;
        trc_wr     = active && trc_valid && !halt_now;
        sw_hold    = cmd.wdata_wr || cmd.wptr_wr;
        hw_wr      = (trc_wr || pad_wr) && !sw_hold;
        flush_done = flush_busy && (aligned || !active);
        ram_we     = cmd.wdata_wr || hw_wr;
        ram_waddr  = wptr;
        if (cmd.wdata_wr)  ram_wdata = cmd.value;
        else if (trc_wr)   ram_wdata = trc_data;
        else               ram_wdata = PAD_WORD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr       <= '0;
            full       <= 1'b0;
            halted     <= 1'b0;
            seen_trig  <= 1'b0;
            flush_busy <= 1'b0;
            tcnt       <= '0;
        end else begin
            if (cmd.wptr_wr) begin
                wptr <= cmd.value[AW-1:0];
                if (!ctl_en) full <= 1'b0;
            end else if (ram_we) begin
                wptr <= wptr + AW'(1);
                if (wptr == '1) full <= 1'b1;
            end

            if (cmd.arm)                      seen_trig <= 1'b0;
            else if (active && trc_trigger)   seen_trig <= 1'b1;

            if (cmd.arm)         halted <= 1'b0;
            else if (halt_now)   halted <= 1'b1;

            if (cmd.flush_req)       flush_busy <= 1'b1;
            else if (flush_done)     flush_busy <= 1'b0;

            if (cmd.tcnt_wr)
                tcnt <= cmd.value[CNT_W-1:0];
            else if (seen_trig && trc_wr && hw_wr && tcnt != '0)
                tcnt <= tcnt - CNT_W'(1);
        end
    end

    // R7
    halt_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(halted) && !$past(cmd.wptr_wr) && !$past(cmd.wdata_wr))
            |-> (wptr[FRAME_LOG2-1:0] == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !cmd.wptr_wr && !cmd.wdata_wr) |=> $stable(wptr));

    // R5
    full_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(full) |-> $past(cmd.wptr_wr && !ctl_en));

    // R8
    flush_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flush_busy) |-> $past(aligned || !active));

    // R6
    tcnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd.tcnt_wr |=> (tcnt == $past(tcnt) || tcnt == $past(tcnt) - CNT_W'(1)));
endmodule

// File: rtl/trs_regs.sv
module trs_regs
    import trs_pkg::*;
#(
    parameter int AW    = 6,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [AW-1:0]     wptr,
    input  logic              full,
    input  logic              halted,
    input  logic              flush_busy,
    input  logic [CNT_W-1:0]  tcnt,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic [AW-1:0]     rptr,
    output logic              ctl_en,
    output halt_cfg_t         cfg,
    output sw_cmd_t           cmd
);
    localparam logic [WORD_W-1:0] DEPTH_WORD = WORD_W'(1 << AW) & 32'h7FFF_FFFF;

    logic              fmt_en;
    logic              rd_data_hit, wr_rptr_hit;
    logic [WORD_W-1:0] rd_mux;

    always_comb begin
        cmd.wptr_wr   = bus_wr && bus_addr == A_WPTR;
        cmd.wdata_wr  = bus_wr && bus_addr == A_WDATA;
        cmd.tcnt_wr   = bus_wr && bus_addr == A_TCNT;
        cmd.flush_req = bus_wr && bus_addr == A_FCTRL && bus_wdata[FC_FLUSH];
        cmd.arm       = bus_wr && bus_addr == A_CTRL && bus_wdata[CT_EN];
        cmd.value     = bus_wdata;
        rd_data_hit   = bus_rd && bus_addr == A_RDATA;
        wr_rptr_hit   = bus_wr && bus_addr == A_RPTR;
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_DEPTH: rd_mux = DEPTH_WORD;
            A_STAT:  rd_mux[ST_FULL] = full;
            A_RDATA: rd_mux = ram_rdata;
            A_RPTR:  rd_mux = WORD_W'(rptr);
            A_WPTR:  rd_mux = WORD_W'(wptr);
            A_TCNT:  rd_mux = WORD_W'(tcnt);
            A_CTRL:  rd_mux[CT_EN] = ctl_en;
            A_FSTAT: rd_mux[FS_HALTED] = halted || !ctl_en;
            A_FCTRL: begin
                rd_mux[FC_FMT_EN]     = fmt_en;
                rd_mux[FC_FLUSH]      = flush_busy;
                rd_mux[FC_STOP_FLUSH] = cfg.stop_flush;
                rd_mux[FC_STOP_TRIG]  = cfg.stop_trig;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            rptr      <= '0;
            ctl_en    <= 1'b0;
            fmt_en    <= 1'b0;
            cfg       <= '0;
        end else begin
            if (bus_rd) bus_rdata <= rd_mux;

            if (wr_rptr_hit)       rptr <= bus_wdata[AW-1:0];
            else if (rd_data_hit)  rptr <= rptr + AW'(1);

            if (bus_wr && bus_addr == A_CTRL) ctl_en <= bus_wdata[CT_EN];

            if (bus_wr && bus_addr == A_FCTRL) begin
                fmt_en         <= bus_wdata[FC_FMT_EN];
                cfg.stop_flush <= bus_wdata[FC_STOP_FLUSH];
                cfg.stop_trig  <= bus_wdata[FC_STOP_TRIG];
            end
        end
    end

    // R2
    rptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data_hit && !wr_rptr_hit) |=> (rptr == $past(rptr) + AW'(1)));

    // R1
    depth_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_DEPTH) |=> !bus_rdata[31]);
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
    import trs_pkg::*;
#(
    parameter int                ADDR_LOG2 = 6,
    parameter int                TCNT_W    = 16,
    parameter logic [31:0]       PAD_WORD  = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] trc_data,
    input  logic        trc_valid,
    input  logic        trc_trigger
);
    logic [ADDR_LOG2-1:0] wptr, rptr, ram_waddr;
    logic                 full, halted, flush_busy, ctl_en, ram_we;
    logic [TCNT_W-1:0]    tcnt;
    logic [WORD_W-1:0]    ram_wdata, ram_rdata;
    halt_cfg_t            cfg;
    sw_cmd_t              cmd;

    trs_regs #(.AW(ADDR_LOG2), .CNT_W(TCNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wptr(wptr), .full(full), .halted(halted), .flush_busy(flush_busy),
        .tcnt(tcnt), .ram_rdata(ram_rdata),
        .rptr(rptr), .ctl_en(ctl_en), .cfg(cfg), .cmd(cmd)
    );

    trs_capture #(.AW(ADDR_LOG2), .CNT_W(TCNT_W), .PAD_WORD(PAD_WORD)) u_cap (
        .clk(clk), .rst(rst), .ctl_en(ctl_en), .cfg(cfg), .cmd(cmd),
        .trc_data(trc_data), .trc_valid(trc_valid), .trc_trigger(trc_trigger),
        .wptr(wptr), .full(full), .halted(halted), .flush_busy(flush_busy),
        .tcnt(tcnt), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
    );

    trs_ram #(.AW(ADDR_LOG2), .DW(WORD_W)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(rptr), .rdata(ram_rdata)
    );
endmodule

// File: tb/tb_trace_ring_sink.sv
module tb_trace_ring_sink;
    localparam int CLK_PERIOD = 10;

    localparam logic [11:0] R_DEPTH = 12'h004, R_STAT = 12'h00C, R_RDATA = 12'h010,
                            R_RPTR = 12'h014, R_WPTR = 12'h018, R_TCNT = 12'h01C,
                            R_CTRL = 12'h020, R_WDATA = 12'h024, R_FSTAT = 12'h300,
                            R_FCTRL = 12'h304;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] trc_data = '0;
    logic        trc_valid = 1'b0, trc_trigger = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_ring_sink dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trc_data(trc_data),
        .trc_valid(trc_valid), .trc_trigger(trc_trigger)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic ram_chk(input string tag, input int idx, input logic [31:0] exp);
        wr(R_RPTR, 32'(idx));
        rd_chk(tag, R_RDATA, exp);
    endtask

    task automatic stream(input int n, input logic [31:0] base, input int trig_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            trc_valid = 1'b1; trc_data = base + 32'(i); trc_trigger = (i == trig_at);
        end
        @(negedge clk); trc_valid = 1'b0; trc_trigger = 1'b0;
    endtask

    task automatic wait_flush();
        logic [31:0] v;
        for (int k = 0; k < 20; k++) begin
            rd(R_FCTRL, v);
            if (!v[6]) break;
        end
    endtask

    task automatic t_reset();
        rd_chk("R11 wptr", R_WPTR, 32'h0);
        rd_chk("R11 rptr", R_RPTR, 32'h0);
        rd_chk("R11 status", R_STAT, 32'h0);
        rd_chk("R11 ctrl", R_CTRL, 32'h0);
        rd_chk("R11 fctrl", R_FCTRL, 32'h0);
        rd_chk("R11 tcnt", R_TCNT, 32'h0);
        rd_chk("R11 fstat", R_FSTAT, 32'h2);
        rd_chk("R1 depth", R_DEPTH, 32'd64);
        wr(R_DEPTH, 32'hFFFF_FFFF);
        rd_chk("R1 depth after write", R_DEPTH, 32'd64);
    endtask

    task automatic t_sw_fill();
        for (int i = 0; i < 64; i++) wr(R_WDATA, 32'hA000_0000 + 32'(i * 3));
        rd_chk("R3 wptr wrapped", R_WPTR, 32'h0);
        rd_chk("R5 full after sw wrap", R_STAT, 32'h1);
        wr(R_RPTR, 32'd62);
        rd_chk("R2 word 62", R_RDATA, 32'hA000_0000 + 32'd186);
        rd_chk("R2 word 63", R_RDATA, 32'hA000_0000 + 32'd189);
        rd_chk("R2 wrap to 0", R_RDATA, 32'hA000_0000);
        rd_chk("R2 rptr after wrap", R_RPTR, 32'h1);
        wr(R_WPTR, 32'h0);
        rd_chk("R5 cleared when disabled", R_STAT, 32'h0);
        wr(R_WPTR, 32'd9);
        wr(R_WDATA, 32'h0000_0055);
        rd_chk("R3 wptr after sw store", R_WPTR, 32'd10);
        ram_chk("R3 sw store at loaded pointer", 9, 32'h55);
        ram_chk("R3 neighbour untouched", 10, 32'hA000_0000 + 32'd30);
        wr(R_WPTR, 32'h0);
    endtask

    task automatic t_capture();
        wr(R_CTRL, 32'h1);
        stream(5, 32'h10, -1);
        wr(R_CTRL, 32'h0);
        stream(3, 32'h20, -1);
        rd_chk("R4 wptr after gated stream", R_WPTR, 32'd5);
        ram_chk("R4 first word", 0, 32'h10);
        ram_chk("R4 last word", 4, 32'h14);
        ram_chk("R4 disabled stream ignored", 5, 32'hA000_0000 + 32'd15);
    endtask

    task automatic t_full_capture();
        wr(R_FCTRL, 32'h0);
        wr(R_WPTR, 32'd60);
        wr(R_CTRL, 32'h1);
        stream(6, 32'h600, -1);
        rd_chk("R5 full after capture wrap", R_STAT, 32'h1);
        rd_chk("R4 wptr after wrap", R_WPTR, 32'd2);
        wr(R_WPTR, 32'd62);
        rd_chk("R5 full kept when enabled", R_STAT, 32'h1);
        wr(R_CTRL, 32'h0);
        ram_chk("R5 RAM kept word 0", 0, 32'h604);
        ram_chk("R5 RAM kept word 61", 61, 32'h601);
        rd_chk("R3 pointer write immediate", R_WPTR, 32'd62);
        wr(R_WPTR, 32'h0);
        rd_chk("R5 clear when disabled", R_STAT, 32'h0);
    endtask

    task automatic t_count();
        wr(R_FCTRL, 32'h0);
        wr(R_TCNT, 32'd5);
        rd_chk("R6 counter readback", R_TCNT, 32'd5);
        wr(R_WPTR, 32'h0);
        wr(R_CTRL, 32'h1);
        stream(4, 32'h700, 1);
        rd_chk("R6 two words after trigger", R_TCNT, 32'd3);
        wr(R_CTRL, 32'h0);
    endtask

    task automatic t_trig_stop();
        for (int i = 0; i < 64; i++) wr(R_WDATA, 32'hFFFF_FFFF);
        wr(R_WPTR, 32'h0);
        wr(R_TCNT, 32'd2);
        wr(R_FCTRL, 32'h2000);
        wr(R_CTRL, 32'h1);
        stream(12, 32'h100, 4);
        rd_chk("R7 wptr frame aligned", R_WPTR, 32'd8);
        rd_chk("R10 halted flag", R_FSTAT, 32'h2);
        rd_chk("R6 counter expired", R_TCNT, 32'h0);
        ram_chk("R7 last counted word", 6, 32'h106);
        ram_chk("R7 frame-fill word", 7, 32'h107);
        ram_chk("R7 nothing after halt", 8, 32'hFFFF_FFFF);
    endtask

    task automatic t_trig_pad();
        wr(R_CTRL, 32'h0);
        rd_chk("R10 disabled reads halted", R_FSTAT, 32'h2);
        wr(R_WPTR, 32'h0);
        wr(R_TCNT, 32'h0);
        wr(R_FCTRL, 32'h2000);
        wr(R_CTRL, 32'h1);
        rd_chk("R10 rearm clears halted", R_FSTAT, 32'h0);
        stream(5, 32'h200, 4);
        repeat (6) @(negedge clk);
        rd_chk("R7 padded to boundary", R_WPTR, 32'd8);
        rd_chk("R10 halted after pad", R_FSTAT, 32'h2);
        ram_chk("R7 trigger word", 4, 32'h204);
        ram_chk("R7 pad slot 5", 5, 32'h0);
        ram_chk("R7 pad slot 7", 7, 32'h0);
        stream(3, 32'h900, -1);
        rd_chk("R7 input ignored after halt", R_WPTR, 32'd8);
    endtask

    task automatic t_flush_stop();
        wr(R_CTRL, 32'h0);
        wr(R_WPTR, 32'h0);
        wr(R_FCTRL, 32'h1000);
        wr(R_CTRL, 32'h1);
        stream(2, 32'h300, -1);
        wr(R_FCTRL, 32'h1040);
        rd_chk("R8 flush bit pending", R_FCTRL, 32'h1040);
        wait_flush();
        rd_chk("R8 flush bit self-cleared", R_FCTRL, 32'h1000);
        rd_chk("R8 flush pads to boundary", R_WPTR, 32'd4);
        rd_chk("R9 halted by flush", R_FSTAT, 32'h2);
        ram_chk("R8 captured before flush", 1, 32'h301);
        ram_chk("R8 pad word", 2, 32'h0);
    endtask

    task automatic t_flush_run();
        wr(R_CTRL, 32'h0);
        wr(R_WPTR, 32'h0);
        wr(R_FCTRL, 32'h0001);
        wr(R_CTRL, 32'h1);
        stream(3, 32'h400, -1);
        wr(R_FCTRL, 32'h0041);
        wait_flush();
        rd_chk("R8 fmt bit kept, flush cleared", R_FCTRL, 32'h1);
        rd_chk("R8 one pad slot", R_WPTR, 32'd4);
        rd_chk("R9 not halted without stop bit", R_FSTAT, 32'h0);
        stream(2, 32'h500, -1);
        rd_chk("R9 capture continues", R_WPTR, 32'd6);
        ram_chk("R9 word after flush", 4, 32'h500);
        ram_chk("R8 pad slot 3", 3, 32'h0);
        wr(R_CTRL, 32'h0);
        wr(R_FCTRL, 32'h40);
        rd_chk("R8 flush done at once when idle", R_FCTRL, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sw_fill();
        t_capture();
        t_full_capture();
        t_count();
        t_trig_stop();
        t_trig_pad();
        t_flush_stop();
        t_flush_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule